// File: doc/BRIEF.md
# Chien-Search Error Locator

This block finds the roots of an error-locator polynomial over GF(2^13) or GF(2^14) and reports where they fall as 1-based bit positions in a codeword. Software writes the locator coefficients and a configuration word, then writes the search length. The length is normally the data bit count of the sector plus m times the correction strength. The engine then tests one codeword position per clock cycle. When it finishes it raises a done flag and reports how many roots it saw. It also fills a short list with the positions of those roots.

The caller compares the root count with the locator degree it programmed. A mismatch marks the sector as uncorrectable. Otherwise each listed position, minus one, gives the byte (position/8) and the bit (position%8) to flip. Byte offsets below the sector size fall in data, those below the sector size plus the parity bytes fall in parity, and anything higher is invalid. A stop command aborts any search and clears the results before the engine is reprogrammed.

Top module: `chien_locator`

## Requirements
- R1: After reset, irq_o is 0, the status register reads 0, every position entry reads 0 and the configuration reads 0.
- R2: The configuration register at byte offset 0x00 holds the locator degree (coefficient count minus one) in bits 20:16. Bit 0 selects GF(2^14) with polynomial 0x4443 for 1024-byte sectors when 1, and GF(2^13) with polynomial 0x201b for 512-byte sectors when 0. The register reads back as written in those fields.
- R3: Coefficient k (bits 13:0) is written at byte offset 0x28 + 4k for k = 0..T. Coefficients with index above the configured degree take no part in the search.
- R4: A write to the length register at 0x04 (bits 15:0, value 1..65535) starts a search. irq_o is 0 until the length-th rising edge after the edge that takes the write, and 1 from that edge on.
- R5: The status register at 0x0C holds done in bit 0 and the root count in bits 12:8. The count saturates at 31. irq_o follows the done bit.
- R6: Position i (1..length) is reported as a root when the locator evaluated at alpha^i is zero. Roots go into the list at 0x100 + 4j (j = 0..T-1) in ascending order. Roots beyond the T-th are counted but not stored, and unused entries read 0.
- R7: The root count equals the number of roots inside the searched range, so a locator whose roots lie outside the range returns a count that differs from its degree.
- R8: Writing 1 to bit 0 of the stop register at 0x08 aborts any search and clears done, the count and the list. A stop write with bit 0 clear has no effect.
- R9: Writes to the configuration or coefficient registers during a search do not change that search's result. A new length write during a search restarts the search from position 1.
- R10: In GF(2^14) mode the search covers the full 1024-byte length of 8192 + 14t positions, including the first and last positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Search-complete flag |

## Verification
The bench builds the block with T = 8, a 16-bit length and a 10-bit address. This gives a list of eight entries, which a zero locator can overflow within twelve positions, and a count that a 40-position search can push to its saturation value. With a 16-bit length, full 512-byte and 1024-byte searches of 4148 and 8304 positions fit well within the run. The bench therefore checks roots at the first and last positions of a real sector, as well as roots placed beyond the programmed length. A behavioural model tracks the done flag on every clock, including through stop and restart.

// File: rtl/chien_pkg.sv
package chien_pkg;

    localparam int GF_W = 14;

    typedef logic [GF_W-1:0] gf_t;

    typedef enum logic [1:0] {
        SRCH_IDLE,
        SRCH_RUN,
        SRCH_DONE
    } srch_state_e;

    typedef struct packed {
        logic [4:0] degree;
        logic       wide;
    } loc_cfg_t;

    localparam int OFS_CFG   = 'h000;
    localparam int OFS_LEN   = 'h004;
    localparam int OFS_STOP  = 'h008;
    localparam int OFS_STAT  = 'h00C;
    localparam int OFS_SIGMA = 'h028;
    localparam int OFS_POS   = 'h100;

    localparam gf_t RED_M14 = 14'h0443;
    localparam gf_t RED_M13 = 14'h001B;

    function automatic gf_t gf_times_alpha(gf_t v, logic wide);
        gf_t r;
        if (wide)
            r = {v[12:0], 1'b0} ^ (v[13] ? RED_M14 : '0);
        else
            r = {1'b0, v[11:0], 1'b0} ^ (v[12] ? RED_M13 : '0);
        return r;
    endfunction

    function automatic gf_t gf_times_alpha_pow(gf_t v, logic wide, int unsigned n);
        gf_t r = v;
        for (int unsigned i = 0; i < n; i++)
            r = gf_times_alpha(r, wide);
        return r;
    endfunction

endpackage

// File: rtl/chien_regs.sv
module chien_regs
    import chien_pkg::*;
#(
    parameter int T      = 8,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic                       stat_done,
    input  logic [4:0]                 stat_count,
    input  logic [T-1:0][LEN_W-1:0]    pos_list,
    output loc_cfg_t                   cfg,
    output logic [T:0][GF_W-1:0]       sigma,
    output logic                       start,
    output logic                       stop,
    output logic [LEN_W-1:0]           len_wr,
    output logic [31:0]                rd_data
);

    localparam int NCOEF = T + 1;

    logic [LEN_W-1:0] len_q;

    assign start  = wr_en && (wr_addr == ADDR_W'(OFS_LEN));
    assign stop   = wr_en && (wr_addr == ADDR_W'(OFS_STOP)) && wr_data[0];
    assign len_wr = wr_data[LEN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            sigma <= '0;
            len_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_CFG)) begin
                cfg.degree <= wr_data[20:16];
                cfg.wide   <= wr_data[0];
            end
            if (start)
                len_q <= wr_data[LEN_W-1:0];
            for (int k = 0; k < NCOEF; k++)
                if (wr_addr == ADDR_W'(OFS_SIGMA + 4 * k))
                    sigma[k] <= wr_data[GF_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CFG))
            rd_data = {11'b0, cfg.degree, 15'b0, cfg.wide};
        if (rd_addr == ADDR_W'(OFS_LEN))
            rd_data = 32'(len_q);
        if (rd_addr == ADDR_W'(OFS_STAT))
            rd_data = {19'b0, stat_count, 7'b0, stat_done};
        for (int k = 0; k < NCOEF; k++)
            if (rd_addr == ADDR_W'(OFS_SIGMA + 4 * k))
                rd_data = 32'(sigma[k]);
        for (int j = 0; j < T; j++)
            if (rd_addr == ADDR_W'(OFS_POS + 4 * j))
                rd_data = 32'(pos_list[j]);
    end

    // R3
    sigma0_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(OFS_SIGMA)) |=> (sigma[0] == $past(wr_data[GF_W-1:0])));

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(OFS_CFG)) |=> (cfg.degree == $past(wr_data[20:16])));

endmodule

// File: rtl/chien_term.sv
module chien_term
    import chien_pkg::*;
#(
    parameter int K = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic advance,
    input  logic wide_ld,
    input  logic wide_run,
    input  logic use_coef,
    input  gf_t  coef,
    output gf_t  term
);

    gf_t coef_m;

    assign coef_m = wide_ld ? coef : (coef & 14'h1FFF);

    always_ff @(posedge clk) begin
        if (rst)
            term <= '0;
        else if (load)
            term <= use_coef ? gf_times_alpha_pow(coef_m, wide_ld, K) : '0;
        else if (advance)
            term <= gf_times_alpha_pow(term, wide_run, K);
    end

endmodule

// File: rtl/chien_ctrl.sv
module chien_ctrl
    import chien_pkg::*;
#(
    parameter int T     = 8,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    stop,
    input  logic [LEN_W-1:0]        len_in,
    input  logic                    wide_in,
    input  gf_t                     term_sum,
    output logic                    advance,
    output logic                    run_wide,
    output logic                    done,
    output logic [4:0]              count,
    output logic [T-1:0][LEN_W-1:0] pos_list
);

    localparam int IDX_W = $clog2(T + 1);

    srch_state_e      state;
    logic [LEN_W-1:0] step;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx;
    logic             hit;

    assign hit     = (term_sum == '0);
    assign advance = (state == SRCH_RUN);
    assign done    = (state == SRCH_DONE);

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            state    <= SRCH_IDLE;
            step     <= '0;
            count    <= '0;
            idx      <= '0;
            pos_list <= '0;
            if (rst) begin
                len_q    <= '0;
                run_wide <= 1'b0;
            end
        end else if (start) begin
            state    <= (len_in == '0) ? SRCH_DONE : SRCH_RUN;
            step     <= LEN_W'(1);
            len_q    <= len_in;
            run_wide <= wide_in;
            count    <= '0;
            idx      <= '0;
            pos_list <= '0;
        end else if (state == SRCH_RUN) begin
            if (hit) begin
                if (count != 5'd31)
                    count <= count + 5'd1;
                if (idx < IDX_W'(T)) begin
                    pos_list[idx] <= step;
                    idx           <= idx + IDX_W'(1);
                end
            end
            if (step == len_q)
                state <= SRCH_DONE;
            else
                step <= step + LEN_W'(1);
        end
    end

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !stop) |=> done);

    // R6
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SRCH_RUN && hit && idx != '0 && idx < IDX_W'(T)) |-> (step > pos_list[idx - IDX_W'(1)]));

    // R4
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SRCH_RUN) |-> (step != '0 && step <= len_q));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!done && count == '0 && pos_list[0] == '0));

endmodule

// File: rtl/chien_locator.sv
module chien_locator
    import chien_pkg::*;
#(
    parameter int T      = 8,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_o
);

    localparam int NCOEF = T + 1;

    loc_cfg_t                   cfg;
    logic [T:0][GF_W-1:0]       sigma;
    logic [NCOEF-1:0][GF_W-1:0] terms;
    logic                       start;
    logic                       stop;
    logic [LEN_W-1:0]           len_wr;
    logic                       advance;
    logic                       run_wide;
    logic                       done;
    logic [4:0]                 count;
    logic [T-1:0][LEN_W-1:0]    pos_list;
    gf_t                        term_sum;

    chien_regs #(.T(T), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .stat_done  (done),
        .stat_count (count),
        .pos_list   (pos_list),
        .cfg        (cfg),
        .sigma      (sigma),
        .start      (start),
        .stop       (stop),
        .len_wr     (len_wr),
        .rd_data    (rd_data)
    );

    for (genvar k = 0; k < NCOEF; k++) begin : g_term
        chien_term #(.K(k)) u_term (
            .clk      (clk),
            .rst      (rst),
            .load     (start),
            .advance  (advance),
            .wide_ld  (cfg.wide),
            .wide_run (run_wide),
            .use_coef (5'(k) <= cfg.degree),
            .coef     (sigma[k]),
            .term     (terms[k])
        );
    end

    always_comb begin
        term_sum = '0;
        for (int k = 0; k < NCOEF; k++)
            term_sum = term_sum ^ terms[k];
    end

    chien_ctrl #(.T(T), .LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .len_in   (len_wr),
        .wide_in  (cfg.wide),
        .term_sum (term_sum),
        .advance  (advance),
        .run_wide (run_wide),
        .done     (done),
        .count    (count),
        .pos_list (pos_list)
    );

    assign irq_o = done;

    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (start && len_wr != '0) |=> !irq_o);

endmodule

// File: tb/chien_locator_tb.sv
module chien_locator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T      = 8;
    localparam int LEN_W  = 16;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              irq_o;

    chien_locator #(.T(T), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    int sh_sig [0:T];
    int sh_deg  = 0;
    bit sh_wide = 0;
    int exp_pos [$];
    int exp_cnt = 0;

    // behavioural done-flag model
    bit m_done = 0;
    bit m_run  = 0;
    int m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_done = 0; m_run = 0; m_left = 0;
        end else if (wr_en && wr_addr == ADDR_W'('h008) && wr_data[0]) begin
            m_done = 0; m_run = 0;
        end else if (wr_en && wr_addr == ADDR_W'('h004)) begin
            m_left = int'(wr_data[15:0]);
            m_run  = (m_left != 0);
            m_done = (m_left == 0);
        end else if (m_run) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                m_run = 0; m_done = 1;
            end
        end
    end

    // R4: done flag compared with the model on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            vectors++;
            if (irq_o !== m_done) begin
                fails++;
                $display("FAIL R4 irq_o actual=%0b expected=%0b at %0t", irq_o, m_done, $time);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gf_mul(input int a_in, input int b, input bit wide);
        int a = a_in;
        int r = 0;
        int m = wide ? 14 : 13;
        int poly = wide ? 'h4443 : 'h201b;
        for (int j = 0; j < 14; j++) begin
            if (((b >> j) & 1) != 0) r = r ^ a;
            a = a << 1;
            if (((a >> m) & 1) != 0) a = a ^ poly;
        end
        return r;
    endfunction

    function automatic int alpha_pow(input int p, input bit wide);
        int x = 1;
        for (int i = 0; i < p; i++) x = gf_mul(x, 2, wide);
        return x;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1; wr_addr = ADDR_W'(addr); wr_data = 32'(data);
        if (addr == 'h000) begin
            sh_deg = (data >> 16) & 31; sh_wide = data[0];
        end
        for (int k = 0; k <= T; k++)
            if (addr == 'h028 + 4 * k) sh_sig[k] = data & 'h3fff;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int addr, output int v);
        rd_addr = ADDR_W'(addr);
        #1;
        v = int'(rd_data);
    endtask

    task automatic load_roots(input int roots [$], input bit wide);
        int c [0:T];
        int nc [0:T];
        int d = 0;
        for (int k = 0; k <= T; k++) c[k] = 0;
        c[0] = 1;
        foreach (roots[i]) begin
            int r = alpha_pow(roots[i], wide);
            for (int k = 0; k <= T; k++)
                nc[k] = gf_mul(c[k], r, wide) ^ ((k > 0) ? c[k-1] : 0);
            c = nc;
            d++;
        end
        wr('h000, (d << 16) | int'(wide));
        for (int k = 0; k <= T; k++) wr('h028 + 4 * k, c[k]);
    endtask

    task automatic start(input int len);
        int x = 1;
        int m = sh_wide ? 14 : 13;
        exp_pos.delete();
        exp_cnt = 0;
        for (int i = 1; i <= len; i++) begin
            int v = 0;
            x = gf_mul(x, 2, sh_wide);
            for (int k = sh_deg; k >= 0; k--) begin
                int ck = (k <= T) ? sh_sig[k] : 0;
                if (m == 13) ck = ck & 'h1fff;
                v = gf_mul(v, x, sh_wide) ^ ck;
            end
            if (v == 0) begin
                if (exp_cnt < 31) exp_cnt++;
                if (exp_pos.size() < T) exp_pos.push_back(i);
            end
        end
        wr('h004, len);
    endtask

    task automatic wait_and_check(input string tag);
        int v;
        while (!m_done) @(negedge clk);
        rd('h00C, v);
        chk({tag, " R5 done bit"}, v & 1, 1);
        chk({tag, " R7 root count"}, (v >> 8) & 31, exp_cnt);
        for (int j = 0; j < T; j++) begin
            rd('h100 + 4 * j, v);
            chk($sformatf("%s R6 position[%0d]", tag, j), v, (j < exp_pos.size()) ? exp_pos[j] : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int v;
        int rl [$];
        for (int k = 0; k <= T; k++) sh_sig[k] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        rd('h00C, v); chk("R1 status", v, 0);
        rd('h000, v); chk("R1 cfg", v, 0);
        rd('h100, v); chk("R1 position[0]", v, 0);
        chk("R1 irq_o", int'(irq_o), 0);

        // R2 / R6: 512-byte sector, t=4, GF(2^13)
        rl = '{5, 100, 2000, 4100};
        load_roots(rl, 1'b0);
        rd('h000, v); chk("R2 cfg readback", v, (4 << 16));
        start(4096 + 13 * 4);
        wait_and_check("m13");

        // R10: 1024-byte sector, first and last positions
        rl = '{1, 3000, 8304};
        load_roots(rl, 1'b1);
        rd('h000, v); chk("R2 cfg wide readback", v, (3 << 16) | 1);
        start(8192 + 14 * 8);
        wait_and_check("R10 m14");

        // R7: roots outside the range
        rl = '{10, 50};
        load_roots(rl, 1'b0);
        start(40);
        wait_and_check("R7 out-of-range");
        rd('h00C, v); chk("R7 count below degree", (v >> 8) & 31, 1);

        // R3: coefficient above degree ignored
        rl = '{7};
        load_roots(rl, 1'b0);
        wr('h028 + 8, 'h1234);
        start(60);
        wait_and_check("R3 masked coef");
        rd('h100, v); chk("R3 root at 7", v, 7);

        // R6: list capacity with a zero locator
        wr('h000, 0);
        for (int k = 0; k <= T; k++) wr('h028 + 4 * k, 0);
        start(12);
        wait_and_check("R6 capacity");
        rd('h00C, v); chk("R6 count beyond list", (v >> 8) & 31, 12);

        // R5: count saturates
        start(40);
        wait_and_check("R5 saturate");
        rd('h00C, v); chk("R5 count 31", (v >> 8) & 31, 31);

        // R8: stop with bit 0 clear has no effect
        wr('h008, 'h2);
        rd('h00C, v); chk("R8 stop bit0=0 keeps done", v & 1, 1);
        chk("R8 stop bit0=0 keeps count", (v >> 8) & 31, 31);

        // R8: abort mid-search
        rl = '{30, 3900};
        load_roots(rl, 1'b0);
        start(4000);
        repeat (100) @(negedge clk);
        wr('h008, 1);
        rd('h00C, v); chk("R8 status cleared", v, 0);
        rd('h100, v); chk("R8 list cleared", v, 0);
        repeat (4100) @(negedge clk);
        chk("R8 irq stays low", int'(irq_o), 0);

        // R9: register writes during a search
        rl = '{20, 250};
        load_roots(rl, 1'b0);
        start(300);
        repeat (30) @(negedge clk);
        wr('h028, 'h0abc);
        wr('h000, (1 << 16) | 1);
        wait_and_check("R9 writes mid-search");

        // R9: restart during a search
        rl = '{100, 200};
        load_roots(rl, 1'b0);
        start(1000);
        repeat (50) @(negedge clk);
        start(150);
        wait_and_check("R9 restart");
        rd('h00C, v); chk("R9 restart count", (v >> 8) & 31, 1);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule